// File: doc/BRIEF.md
# Inter-processor soft interrupt dispatcher

This block keeps the software-generated interrupt state of a multi-core interrupt distributor. A requesting core issues a write that carries a 4-bit interrupt ID, a 2-bit list type and an 8-bit target field. The block then sets pending bits for the cores that the write selects. A core's acknowledge moves one pending bit to active. Its end-of-interrupt clears that active bit. Priority arbitration and bus decode sit outside the block. The arbiter sees the pending and active state per core and per ID as two flat vectors.

There are two addressing modes, and a runtime control bit chooses between them. The compact mode serves up to eight cores. For each ID it holds a 64-bit vector that records which source signalled which target, and an acknowledge reports the source core. The wide mode serves up to 256 cores. It holds a 16-bit pending vector and a 16-bit active vector for each core. In this mode the target field names a single core. The state held in one mode is kept when the block switches to the other. Both sets of state are ORed onto the outputs.

Top module: `ipi_dispatch`

## Requirements
- R1: In compact mode (`ext_mode`=0), list type 0 treats `sgi_tgt` as a bitmask. Bit t set marks core t as a target, for t below 8. Bit (8*src + t) of the ID's source vector is set. The result shows as `pend_vec` bit (16*t + id).
- R2: List type 1 marks every enabled core as a target, in both modes.
- R3: List type 2 marks only the requesting core `sgi_src` as the target, in both modes.
- R4: In wide mode (`ext_mode`=1), list type 0 treats `sgi_tgt` as one core number. A number at or above NUM_CORES sets nothing. List type 3 sets nothing in either mode.
- R5: A core whose `core_en` bit is 0 never gets a pending bit set, whatever the list type.
- R6: In compact mode, an acknowledge reports on `ack_src` the lowest source whose pending bit for (`ack_core`, `ack_id`) is set, and raises `ack_hit`. On the next edge that one bit moves from pending to active. Pending bits from other sources stay set.
- R7: In wide mode, an acknowledge moves bit `ack_id` of the core's pending vector into its active vector. It reports `ack_src`=0.
- R8: Reset clears `ext_mode`. A control write with bit 9 set enables wide mode, and a control write with bit 9 clear disables it.
- R9: `ctl_rdata` returns ((NUM_CORES-1)<<5) | (LINE_GROUPS-1) | 0x100. With the default parameters this is 0x1E1.
- R10: End-of-interrupt clears the active bit it names. In compact mode it names (`eoi_core`, `eoi_id`, `eoi_src`); in wide mode it names (`eoi_core`, `eoi_id`).
- R11: An end-of-interrupt for a bit that is not active in the current mode leaves all state unchanged. It sets `eoi_err`, which stays set until reset.
- R12: Pending bits from a write show on `pend_vec` only after the next clock edge. A write and an acknowledge of the same bit in the same cycle leave that bit both active and pending.
- R13: An acknowledge with no matching pending bit gives `ack_hit`=0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data; bit 9 selects the mode |
| ctl_rdata | output | 32 | Control register read value |
| ext_mode | output | 1 | 1 when wide mode is on |
| core_en | input | NUM_CORES | Per-core interface enable |
| sgi_we | input | 1 | Soft interrupt request strobe |
| sgi_src | input | 8 | Requesting core |
| sgi_id | input | 4 | Interrupt ID |
| sgi_list | input | 2 | List type |
| sgi_tgt | input | 8 | Target bitmask (compact) or core number (wide) |
| ack_req | input | 1 | Acknowledge strobe |
| ack_core | input | 8 | Acknowledging core |
| ack_id | input | 4 | Acknowledged ID |
| ack_hit | output | 1 | Acknowledge found a pending bit |
| ack_src | output | 8 | Reported source core |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_core | input | 8 | Completing core |
| eoi_id | input | 4 | Completed ID |
| eoi_src | input | 8 | Source of the completed interrupt (compact mode) |
| eoi_err | output | 1 | Sticky end-of-interrupt error |
| pend_vec | output | NUM_CORES*16 | Pending bit per core and ID, at bit 16*core+id |
| act_vec | output | NUM_CORES*16 | Active bit per core and ID, at bit 16*core+id |

## Verification
A new request and an acknowledge can both land on the same core and ID in one cycle. The set and the clear of that pending bit then meet at the same edge. The bench provokes this in wide mode. It leaves core 2, ID 5 pending, then raises `sgi_we` and `ack_req` for that bit together. After the edge it expects the bit to be set in both `pend_vec` and `act_vec`. The same bench also runs compact mode with two sources pending on one target, so that the lowest-source choice and the partial clear are judged one acknowledge at a time.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NUM_CORES   = 8,
  parameter int LINE_GROUPS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctl_we,
  input  logic [31:0]             ctl_wdata,
  output logic [31:0]             ctl_rdata,
  output logic                    ext_mode,
  input  logic [NUM_CORES-1:0]    core_en,
  input  logic                    sgi_we,
  input  logic [7:0]              sgi_src,
  input  logic [3:0]              sgi_id,
  input  logic [1:0]              sgi_list,
  input  logic [7:0]              sgi_tgt,
  input  logic                    ack_req,
  input  logic [7:0]              ack_core,
  input  logic [3:0]              ack_id,
  output logic                    ack_hit,
  output logic [7:0]              ack_src,
  input  logic                    eoi_req,
  input  logic [7:0]              eoi_core,
  input  logic [3:0]              eoi_id,
  input  logic [7:0]              eoi_src,
  output logic                    eoi_err,
  output logic [NUM_CORES*16-1:0] pend_vec,
  output logic [NUM_CORES*16-1:0] act_vec
);
  localparam int LEG = (NUM_CORES < 8) ? NUM_CORES : 8;

  logic [15:0][63:0]          leg_pend, leg_act, leg_set, leg_clr, leg_eoi;
  logic [NUM_CORES-1:0][15:0] ext_pend, ext_act, ext_set, ext_clr, ext_eoi;
  logic                       eoi_ok;

  assign ctl_rdata = 32'((NUM_CORES - 1) << 5) | 32'(LINE_GROUPS - 1) | 32'h100;

  always_comb begin
    leg_set = '0;
    ext_set = '0;
    if (sgi_we) begin
      if (ext_mode) begin
        for (int c = 0; c < NUM_CORES; c++) begin
          logic hit;
          case (sgi_list)
            2'd0:    hit = (c == int'(sgi_tgt));
            2'd1:    hit = 1'b1;
            2'd2:    hit = (c == int'(sgi_src));
            default: hit = 1'b0;
          endcase
          if (hit && core_en[c]) ext_set[c][sgi_id] = 1'b1;
        end
      end else begin
        for (int s = 0; s < LEG; s++) begin
          for (int t = 0; t < LEG; t++) begin
            logic hit;
            case (sgi_list)
              2'd0:    hit = sgi_tgt[t];
              2'd1:    hit = 1'b1;
              2'd2:    hit = (t == int'(sgi_src));
              default: hit = 1'b0;
            endcase
            if (s == int'(sgi_src) && hit && core_en[t])
              leg_set[sgi_id][6'(8*s+t)] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ack_hit = 1'b0;
    ack_src = '0;
    leg_clr = '0;
    ext_clr = '0;
    if (ack_req) begin
      if (ext_mode) begin
        for (int c = 0; c < NUM_CORES; c++)
          if (c == int'(ack_core) && ext_pend[c][ack_id]) begin
            ack_hit = 1'b1;
            ext_clr[c][ack_id] = 1'b1;
          end
      end else begin
        for (int s = LEG - 1; s >= 0; s--)
          for (int c = 0; c < LEG; c++)
            if (c == int'(ack_core) && leg_pend[ack_id][6'(8*s+c)]) begin
              ack_hit = 1'b1;
              ack_src = 8'(s);
            end
        if (ack_hit)
          for (int s = 0; s < LEG; s++)
            for (int c = 0; c < LEG; c++)
              if (s == int'(ack_src) && c == int'(ack_core))
                leg_clr[ack_id][6'(8*s+c)] = 1'b1;
      end
    end
  end

  always_comb begin
    eoi_ok  = 1'b0;
    leg_eoi = '0;
    ext_eoi = '0;
    if (eoi_req) begin
      if (ext_mode) begin
        for (int c = 0; c < NUM_CORES; c++)
          if (c == int'(eoi_core) && ext_act[c][eoi_id]) begin
            eoi_ok = 1'b1;
            ext_eoi[c][eoi_id] = 1'b1;
          end
      end else begin
        for (int s = 0; s < LEG; s++)
          for (int c = 0; c < LEG; c++)
            if (s == int'(eoi_src) && c == int'(eoi_core) && leg_act[eoi_id][6'(8*s+c)]) begin
              eoi_ok = 1'b1;
              leg_eoi[eoi_id][6'(8*s+c)] = 1'b1;
            end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mode <= 1'b0;
      eoi_err  <= 1'b0;
      leg_pend <= '0;
      leg_act  <= '0;
      ext_pend <= '0;
      ext_act  <= '0;
    end else begin
      if (ctl_we) ext_mode <= ctl_wdata[9];
      if (eoi_req && !eoi_ok) eoi_err <= 1'b1;
      leg_pend <= (leg_pend & ~leg_clr) | leg_set;
      leg_act  <= (leg_act & ~leg_eoi) | leg_clr;
      ext_pend <= (ext_pend & ~ext_clr) | ext_set;
      ext_act  <= (ext_act & ~ext_eoi) | ext_clr;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++)
      for (int i = 0; i < 16; i++) begin
        logic lp, la;
        lp = 1'b0;
        la = 1'b0;
        for (int s = 0; s < LEG; s++)
          if (c < LEG) begin
            lp = lp | leg_pend[i][6'(8*s+c)];
            la = la | leg_act[i][6'(8*s+c)];
          end
        pend_vec[16*c+i] = ext_pend[c][i] | lp;
        act_vec[16*c+i]  = ext_act[c][i] | la;
      end
  end

  a_r8_mode_follows_bit9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ext_mode == $past(ctl_wdata[9]));

  a_r7_wide_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && ack_hit) |-> ack_src == 8'd0);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_err |=> eoi_err);

  a_r12_no_rise_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sgi_we |=> (pend_vec & ~$past(pend_vec)) == '0);

  a_r6_ack_makes_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !eoi_req) |=> act_vec != '0);

  a_r13_empty_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_hit && !sgi_we && !eoi_req) |=> ($stable(pend_vec) && $stable(act_vec)));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_dis
    a_r5_disabled_core_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (sgi_we && !core_en[g]) |=> (pend_vec[16*g +: 16] & ~$past(pend_vec[16*g +: 16])) == 16'h0);
  end
endmodule

// File: tb/ipi_dispatch_bench.sv
module ipi_dispatch_bench;
  localparam int PERIOD = 10;
  localparam int NC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0; logic [31:0] ctl_wdata = 0; logic [31:0] ctl_rdata; logic ext_mode;
  logic [NC-1:0] core_en = '1;
  logic sgi_we = 0; logic [7:0] sgi_src = 0; logic [3:0] sgi_id = 0; logic [1:0] sgi_list = 0; logic [7:0] sgi_tgt = 0;
  logic ack_req = 0; logic [7:0] ack_core = 0; logic [3:0] ack_id = 0; logic ack_hit; logic [7:0] ack_src;
  logic eoi_req = 0; logic [7:0] eoi_core = 0; logic [3:0] eoi_id = 0; logic [7:0] eoi_src = 0; logic eoi_err;
  logic [NC*16-1:0] pend_vec, act_vec;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  ipi_dispatch u_ipi_dispatch (.*);

  typedef struct packed {
    logic       mode; logic [7:0] src; logic [3:0] id; logic [1:0] list;
    logic [7:0] tgt;  logic [7:0] en;  logic [7:0] exp_cores;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 8'd1, 4'd3,  2'd0, 8'h25, 8'hFF, 8'h25},
    '{1'b0, 8'd4, 4'd0,  2'd1, 8'h00, 8'hEF, 8'hEF},
    '{1'b0, 8'd6, 4'd15, 2'd2, 8'h00, 8'hFF, 8'h40},
    '{1'b0, 8'd0, 4'd1,  2'd0, 8'h0F, 8'hF0, 8'h00},
    '{1'b1, 8'd2, 4'd7,  2'd0, 8'd5,  8'hFF, 8'h20},
    '{1'b1, 8'd2, 4'd7,  2'd0, 8'd9,  8'hFF, 8'h00},
    '{1'b1, 8'd0, 4'd2,  2'd1, 8'h00, 8'h7F, 8'h7F},
    '{1'b1, 8'd3, 4'd9,  2'd2, 8'h00, 8'hFF, 8'h08},
    '{1'b1, 8'd3, 4'd9,  2'd2, 8'h00, 8'hF7, 8'h00},
    '{1'b0, 8'd1, 4'd4,  2'd3, 8'hFF, 8'hFF, 8'h00}
  };

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NC*16-1:0] bitmap(logic [7:0] cores, logic [3:0] id);
    logic [NC*16-1:0] r = '0;
    for (int c = 0; c < NC; c++) if (cores[c]) r[16*c+id] = 1'b1;
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic set_mode(logic m);
    ctl_we = 1; ctl_wdata = m ? 32'h200 : 32'h0;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic send(logic [7:0] s, logic [3:0] i, logic [1:0] l, logic [7:0] t);
    sgi_we = 1; sgi_src = s; sgi_id = i; sgi_list = l; sgi_tgt = t;
    @(negedge clk); sgi_we = 0;
  endtask

  task automatic eoi(logic [7:0] c, logic [3:0] i, logic [7:0] s);
    eoi_req = 1; eoi_core = c; eoi_id = i; eoi_src = s;
    @(negedge clk); eoi_req = 0;
  endtask

  initial begin
    #(PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] p0, a0;
    do_reset();
    chk("R8 reset mode", 128'(ext_mode), 128'd0);
    chk("R9 ctl read", 128'(ctl_rdata), 128'h1E1);
    chk("R12 reset pend", 128'(pend_vec), 128'd0);
    chk("R11 reset err", 128'(eoi_err), 128'd0);

    foreach (VECS[k]) begin
      do_reset();
      set_mode(VECS[k].mode);
      core_en = VECS[k].en;
      send(VECS[k].src, VECS[k].id, VECS[k].list, VECS[k].tgt);
      chk($sformatf("R1 R2 R3 R4 R5 vector %0d", k), 128'(pend_vec), 128'(bitmap(VECS[k].exp_cores, VECS[k].id)));
      core_en = '1;
    end

    do_reset();
    set_mode(1'b1);
    chk("R8 enable", 128'(ext_mode), 128'd1);
    ctl_we = 1; ctl_wdata = 32'h100; @(negedge clk); ctl_we = 0;
    chk("R8 disable", 128'(ext_mode), 128'd0);

    do_reset();
    sgi_we = 1; sgi_src = 0; sgi_id = 2; sgi_list = 2;
    #(PERIOD/2 - 1);
    chk("R12 not same cycle", 128'(pend_vec), 128'd0);
    @(negedge clk); sgi_we = 0;
    chk("R12 next cycle", 128'(pend_vec), 128'(bitmap(8'h01, 4'd2)));

    do_reset();
    send(8'd5, 4'd4, 2'd0, 8'h02);
    send(8'd2, 4'd4, 2'd0, 8'h02);
    ack_req = 1; ack_core = 1; ack_id = 4; #1;
    chk("R6 lowest src", 128'(ack_src), 128'd2);
    chk("R6 hit", 128'(ack_hit), 128'd1);
    @(negedge clk); ack_req = 0;
    chk("R6 still pending other src", 128'(pend_vec), 128'(bitmap(8'h02, 4'd4)));
    chk("R6 active", 128'(act_vec), 128'(bitmap(8'h02, 4'd4)));
    ack_req = 1; #1;
    chk("R6 second src", 128'(ack_src), 128'd5);
    @(negedge clk); ack_req = 0;
    chk("R6 pending drained", 128'(pend_vec), 128'd0);
    eoi(8'd1, 4'd4, 8'd2);
    chk("R10 one src still active", 128'(act_vec), 128'(bitmap(8'h02, 4'd4)));
    eoi(8'd1, 4'd4, 8'd5);
    chk("R10 active cleared", 128'(act_vec), 128'd0);
    chk("R11 no err on good eoi", 128'(eoi_err), 128'd0);
    eoi(8'd1, 4'd4, 8'd5);
    chk("R11 err set", 128'(eoi_err), 128'd1);
    chk("R11 state unchanged", 128'(act_vec | pend_vec), 128'd0);

    do_reset();
    set_mode(1'b1);
    send(8'd0, 4'd9, 2'd0, 8'd3);
    ack_req = 1; ack_core = 3; ack_id = 9; #1;
    chk("R7 src zero", 128'(ack_src), 128'd0);
    chk("R7 hit", 128'(ack_hit), 128'd1);
    @(negedge clk); ack_req = 0;
    chk("R7 pending moved", 128'(pend_vec), 128'd0);
    chk("R7 active set", 128'(act_vec), 128'(bitmap(8'h08, 4'd9)));
    eoi(8'd3, 4'd9, 8'd0);
    chk("R10 wide eoi", 128'(act_vec), 128'd0);
    chk("R11 no err", 128'(eoi_err), 128'd0);
    eoi(8'd3, 4'd9, 8'd0);
    chk("R11 wide err", 128'(eoi_err), 128'd1);
    @(negedge clk);
    chk("R11 err sticky", 128'(eoi_err), 128'd1);

    send(8'd0, 4'd6, 2'd0, 8'd4);
    p0 = 128'(pend_vec); a0 = 128'(act_vec);
    ack_req = 1; ack_core = 0; ack_id = 1; #1;
    chk("R13 no hit", 128'(ack_hit), 128'd0);
    @(negedge clk); ack_req = 0;
    chk("R13 pend unchanged", 128'(pend_vec), p0);
    chk("R13 act unchanged", 128'(act_vec), a0);

    do_reset();
    set_mode(1'b1);
    send(8'd2, 4'd5, 2'd2, 8'h00);
    sgi_we = 1; sgi_src = 2; sgi_id = 5; sgi_list = 2;
    ack_req = 1; ack_core = 2; ack_id = 5;
    @(negedge clk); sgi_we = 0; ack_req = 0;
    chk("R12 same-cycle pending", 128'(pend_vec), 128'(bitmap(8'h04, 4'd5)));
    chk("R12 same-cycle active", 128'(act_vec), 128'(bitmap(8'h04, 4'd5)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule